// File: doc/BRIEF.md
# Manchester Line Transmitter with Preamble and Delimiter Framing

This block turns parallel characters into a single biphase-encoded serial line. Every encoded bit has a level change at its middle. The direction of that change gives the bit's value, and a polarity control can reverse it. In front of each character the block can send a training preamble of up to fifteen bit times. The preamble uses one of four patterns. After the preamble comes a start marker. The marker is either a single encoded zero or a three-bit-time sync shape that deliberately breaks the biphase rule. The data bits follow, least significant first, and the character is five to eight bits long.

An external baud generator supplies a one-cycle `bit_tick` at each bit boundary, every `2*HALF_CYC` clocks. An internal counter marks the mid-bit point `HALF_CYC` clocks after each tick. A producer offers a character with `tx_valid` and the block takes it when `tx_ready` is high. The framing configuration is captured at that moment and held for the whole frame. Transmission begins at the first tick after acceptance. The line rests high whenever no frame is being sent.

Top module: `manchester_tx`

## Requirements
- R1: While reset is asserted and right after it is released, `line_out` is 1, `busy` is 0 and `tx_ready` is 1.
- R2: A character is taken only in a cycle where `tx_valid` and `tx_ready` are both 1. From that edge until the frame ends, `tx_ready` is 0 and `busy` is 1, and `tx_valid` or `tx_data` changes during the frame do not alter what is sent.
- R3: `line_out` is 1 while no frame is on the line, including the wait between acceptance and the first bit tick. The frame's first half-bit starts at the clock edge that samples the first `bit_tick` after acceptance.
- R4: With `cfg_invert`=0, a 0 bit is sent low then high and a 1 bit is sent high then low. Each half lasts `HALF_CYC` clocks.
- R5: With `cfg_invert`=1, both mappings are reversed: a 0 bit is high then low and a 1 bit is low then high.
- R6: `cfg_pre_len` gives the preamble length in bit times (0 to 15). A value of 0 sends no preamble.
- R7: `cfg_pre_pat` picks the preamble bits: 0 = all ones, 1 = all zeros, 2 = alternating starting with one, 3 = alternating starting with zero. Each bit is encoded as in R4/R5.
- R8: With `cfg_sync`=0, the delimiter is one encoded 0 bit.
- R9: With `cfg_sync`=1, the delimiter is three half-bits at the first-half level of an encoded 0, then three half-bits at the opposite level.
- R10: The data bits are sent LSB first. There are 5 + `cfg_len_sel` of them (`cfg_len_sel` 0..3 gives 5..8 bits).
- R11: Changes to the configuration inputs after acceptance have no effect on the frame in flight.
- R12: The order within a frame is preamble, then delimiter, then data. The frame ends at the `bit_tick` edge that closes the last half-bit. At that edge `line_out` returns to 1, `busy` to 0 and `tx_ready` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle pulse at each bit boundary |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Block can take a character |
| tx_data | input | DATA_W | Character, LSB sent first |
| cfg_pre_pat | input | 2 | Preamble pattern select |
| cfg_pre_len | input | PLEN_W | Preamble length in bit times |
| cfg_invert | input | 1 | Reverse transition polarity |
| cfg_sync | input | 1 | 1: three-bit-time sync delimiter, 0: single start bit |
| cfg_len_sel | input | LSEL_W | Character length minus MIN_CHAR |
| line_out | output | 1 | Encoded serial line, idles high |
| busy | output | 1 | Frame accepted and not yet finished |

## Verification
A wrong segment or bit counter in the sequencer shows up at once as a half-bit of the wrong level. It can also show as a frame whose length is off, which moves the return of `tx_ready` by a whole bit time. A wrong half-phase flag or timer value puts a level change away from the tick or mid-bit point, so it is visible within one half-bit. Because every half-bit of every frame is compared with an independently computed waveform, an error in the pattern, polarity or delimiter decode appears within the segment where it occurs.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic [2:0] {
    SEG_IDLE  = 3'd0,
    SEG_ARMED = 3'd1,
    SEG_PRE   = 3'd2,
    SEG_SFD   = 3'd3,
    SEG_DATA  = 3'd4
  } seg_e;

  typedef enum logic [1:0] {
    PAT_ONES    = 2'd0,
    PAT_ZEROS   = 2'd1,
    PAT_ONEZERO = 2'd2,
    PAT_ZEROONE = 2'd3
  } pre_pat_e;

endpackage

// File: rtl/mtx_halfbit_timer.sv
module mtx_halfbit_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic bit_tick,
  output logic mid_pulse
);
  localparam int TW = $clog2(HALF_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(HALF_CYC);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (bit_tick)               cnt_d = TW'(1);
    else if (cnt_q == LAST)     cnt_d = '0;
    else if (cnt_q != '0)       cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign mid_pulse = (cnt_q == LAST);
endmodule

// File: rtl/mtx_frame_seq.sv
module mtx_frame_seq
  import mtx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PLEN_W   = 4,
  parameter int LSEL_W   = 2,
  parameter int MIN_CHAR = 5,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bit_tick,
  input  logic              mid_pulse,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [1:0]        cfg_pre_pat,
  input  logic [PLEN_W-1:0] cfg_pre_len,
  input  logic              cfg_invert,
  input  logic              cfg_sync,
  input  logic [LSEL_W-1:0] cfg_len_sel,
  output logic              tx_ready,
  output seg_e              seg,
  output logic [CNT_W-1:0]  cnt,
  output logic              hsel,
  output logic              data_lsb,
  output pre_pat_e          pat_q,
  output logic              inv_q,
  output logic              sync_q
);
  seg_e              seg_q, seg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, dlast_q, dlast_d;
  logic              hsel_q, hsel_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  pre_pat_e          pat_d;
  logic [PLEN_W-1:0] plen_q, plen_d;
  logic              inv_d, sync_d;
  logic              step;
  logic [CNT_W-1:0]  seg_last;

  assign step = bit_tick | mid_pulse;

  always_comb begin
    case (seg_q)
      SEG_PRE:  seg_last = CNT_W'(plen_q) - CNT_W'(1);
      SEG_SFD:  seg_last = sync_q ? CNT_W'(2) : CNT_W'(0);
      default:  seg_last = dlast_q;
    endcase
  end

  always_comb begin
    seg_d   = seg_q;
    cnt_d   = cnt_q;
    hsel_d  = hsel_q;
    sh_d    = sh_q;
    dlast_d = dlast_q;
    pat_d   = pat_q;
    plen_d  = plen_q;
    inv_d   = inv_q;
    sync_d  = sync_q;
    case (seg_q)
      SEG_IDLE: begin
        if (tx_valid) begin
          seg_d   = SEG_ARMED;
          sh_d    = tx_data;
          pat_d   = pre_pat_e'(cfg_pre_pat);
          plen_d  = cfg_pre_len;
          inv_d   = cfg_invert;
          sync_d  = cfg_sync;
          dlast_d = CNT_W'(MIN_CHAR - 1) + CNT_W'(cfg_len_sel);
        end
      end
      SEG_ARMED: begin
        if (bit_tick) begin
          cnt_d  = '0;
          hsel_d = 1'b0;
          seg_d  = (plen_q != '0) ? SEG_PRE : SEG_SFD;
        end
      end
      default: begin
        if (step) begin
          if (!hsel_q) begin
            hsel_d = 1'b1;
          end else begin
            hsel_d = 1'b0;
            if (seg_q == SEG_DATA) sh_d = {1'b0, sh_q[DATA_W-1:1]};
            if (cnt_q == seg_last) begin
              cnt_d = '0;
              case (seg_q)
                SEG_PRE: seg_d = SEG_SFD;
                SEG_SFD: seg_d = SEG_DATA;
                default: seg_d = SEG_IDLE;
              endcase
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q   <= SEG_IDLE;
      cnt_q   <= '0;
      hsel_q  <= 1'b0;
      sh_q    <= '0;
      dlast_q <= '0;
      pat_q   <= PAT_ONES;
      plen_q  <= '0;
      inv_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      seg_q   <= seg_d;
      cnt_q   <= cnt_d;
      hsel_q  <= hsel_d;
      sh_q    <= sh_d;
      dlast_q <= dlast_d;
      pat_q   <= pat_d;
      plen_q  <= plen_d;
      inv_q   <= inv_d;
      sync_q  <= sync_d;
    end
  end

  assign tx_ready = (seg_q == SEG_IDLE);
  assign seg      = seg_q;
  assign cnt      = cnt_q;
  assign hsel     = hsel_q;
  assign data_lsb = sh_q[0];
endmodule

// File: rtl/mtx_line_encoder.sv
module mtx_line_encoder
  import mtx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  seg_e             seg,
  input  logic [CNT_W-1:0] cnt,
  input  logic             hsel,
  input  logic             data_lsb,
  input  pre_pat_e         pat,
  input  logic             inv,
  input  logic             sync,
  output logic             line
);
  logic bval;
  logic first_lvl;
  logic sync_early;

  always_comb begin
    bval = 1'b0;
    case (pat)
      PAT_ONES:    bval = (seg == SEG_PRE);
      PAT_ZEROS:   bval = 1'b0;
      PAT_ONEZERO: bval = ~cnt[0];
      PAT_ZEROONE: bval = cnt[0];
      default:     bval = 1'b0;
    endcase
    if (seg == SEG_DATA) bval = data_lsb;
    if (seg == SEG_SFD)  bval = 1'b0;
    first_lvl  = bval ^ inv;
    sync_early = (cnt == '0) || ((cnt == CNT_W'(1)) && !hsel);
    case (seg)
      SEG_PRE, SEG_DATA: line = hsel ? ~first_lvl : first_lvl;
      SEG_SFD: begin
        if (sync) line = sync_early ? inv : ~inv;
        else      line = hsel ? ~first_lvl : first_lvl;
      end
      default:  line = 1'b1;
    endcase
  end
endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
  import mtx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PLEN_W   = 4,
  parameter int LSEL_W   = 2,
  parameter int MIN_CHAR = 5,
  parameter int HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [1:0]        cfg_pre_pat,
  input  logic [PLEN_W-1:0] cfg_pre_len,
  input  logic              cfg_invert,
  input  logic              cfg_sync,
  input  logic [LSEL_W-1:0] cfg_len_sel,
  output logic              line_out,
  output logic              busy
);
  localparam int DW_BITS = $clog2(DATA_W + 1);
  localparam int CNT_W   = (PLEN_W > DW_BITS) ? PLEN_W : DW_BITS;

  logic             rst_meta_q, rst_sync_q;
  logic             mid_pulse;
  seg_e             seg;
  logic [CNT_W-1:0] cnt;
  logic             hsel, data_lsb, inv_q, sync_q;
  pre_pat_e         pat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mtx_halfbit_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_ni(rst_sync_q), .bit_tick(bit_tick), .mid_pulse(mid_pulse)
  );

  mtx_frame_seq #(
    .DATA_W(DATA_W), .PLEN_W(PLEN_W), .LSEL_W(LSEL_W),
    .MIN_CHAR(MIN_CHAR), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_ni(rst_sync_q), .bit_tick(bit_tick), .mid_pulse(mid_pulse),
    .tx_valid(tx_valid), .tx_data(tx_data), .cfg_pre_pat(cfg_pre_pat),
    .cfg_pre_len(cfg_pre_len), .cfg_invert(cfg_invert), .cfg_sync(cfg_sync),
    .cfg_len_sel(cfg_len_sel), .tx_ready(tx_ready), .seg(seg), .cnt(cnt),
    .hsel(hsel), .data_lsb(data_lsb), .pat_q(pat_q), .inv_q(inv_q), .sync_q(sync_q)
  );

  mtx_line_encoder #(.CNT_W(CNT_W)) u_enc (
    .seg(seg), .cnt(cnt), .hsel(hsel), .data_lsb(data_lsb),
    .pat(pat_q), .inv(inv_q), .sync(sync_q), .line(line_out)
  );

  assign busy = (seg != SEG_IDLE);
endmodule

// File: rtl/mtx_checker.sv
module mtx_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic mid_pulse,
  input logic tx_valid,
  input logic tx_ready,
  input logic busy,
  input logic line_out,
  input logic inv_q,
  input logic sync_q
);
  p_accept_handshake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(tx_valid) && $past(tx_ready)));

  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line_out);

  p_edges_on_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_out) |-> ($past(bit_tick) || $past(mid_pulse)));

  p_cfg_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(inv_q) && $stable(sync_q)));

  p_end_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bit_tick));
endmodule

bind manchester_tx mtx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mid_pulse(mid_pulse),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .busy(busy), .line_out(line_out),
  .inv_q(inv_q), .sync_q(sync_q)
);

// File: tb/manchester_tx_test.sv
`timescale 1ns/1ps
module manchester_tx_test;
  localparam int HALF = 4;

  logic       clk;
  logic       rst_n;
  logic       bit_tick;
  logic       tx_valid;
  logic       tx_ready;
  logic [7:0] tx_data;
  logic [1:0] cfg_pre_pat;
  logic [3:0] cfg_pre_len;
  logic       cfg_invert;
  logic       cfg_sync;
  logic [1:0] cfg_len_sel;
  logic       line_out;
  logic       busy;

  int  n_chk;
  int  n_err;
  bit  done;
  logic [3:0] ph;

  logic  exp_h [0:63];
  string exp_t [0:63];
  int    nh;

  manchester_tx #(.HALF_CYC(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .cfg_pre_pat(cfg_pre_pat),
    .cfg_pre_len(cfg_pre_len), .cfg_invert(cfg_invert), .cfg_sync(cfg_sync),
    .cfg_len_sel(cfg_len_sel), .line_out(line_out), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial ph = 4'd1;
  always @(negedge clk) ph <= (ph == 4'(2*HALF-1)) ? 4'd0 : ph + 4'd1;
  assign bit_tick = (ph == 4'd0);

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put_bit(input logic b, input logic inv, input string tag);
    exp_h[nh] = b ^ inv;     exp_t[nh] = tag; nh++;
    exp_h[nh] = ~(b ^ inv);  exp_t[nh] = tag; nh++;
  endtask

  task automatic build(input logic [1:0] pat, input int plen, input logic inv,
                       input logic sync, input int clen, input logic [7:0] d);
    logic b;
    nh = 0;
    for (int i = 0; i < plen; i++) begin
      case (pat)
        2'd0: b = 1'b1;
        2'd1: b = 1'b0;
        2'd2: b = (i % 2 == 0);
        default: b = (i % 2 == 1);
      endcase
      put_bit(b, inv, "R7 preamble (R6 length)");
    end
    if (sync) begin
      for (int k = 0; k < 6; k++) begin
        exp_h[nh] = (k < 3) ? inv : ~inv;
        exp_t[nh] = "R9 sync delimiter";
        nh++;
      end
    end else begin
      put_bit(1'b0, inv, "R8 start bit");
    end
    for (int i = 0; i < clen; i++)
      put_bit(d[i], inv, inv ? "R10 data, R5 inverted" : "R10 data, R4 default");
  endtask

  task automatic run_frame(input logic [1:0] pat, input int plen, input logic inv,
                           input logic sync, input logic [1:0] lsel,
                           input logic [7:0] d, input bit noisy);
    build(pat, plen, inv, sync, 5 + int'(lsel), d);
    while (!tx_ready) step();
    tx_data = d; cfg_pre_pat = pat; cfg_pre_len = 4'(plen);
    cfg_invert = inv; cfg_sync = sync; cfg_len_sel = lsel;
    tx_valid = 1'b1;
    step();
    // R11: scramble configuration after acceptance
    cfg_pre_pat = ~pat; cfg_pre_len = ~4'(plen); cfg_invert = ~inv;
    cfg_sync = ~sync; cfg_len_sel = ~lsel;
    if (noisy) tx_data = ~d;
    else       tx_valid = 1'b0;
    chk("R2 busy after accept", busy, 1'b1);
    chk("R2 ready low after accept", tx_ready, 1'b0);
    while (!bit_tick) begin
      chk("R3 line high before first tick", line_out, 1'b1);
      step();
    end
    chk("R3 line high before first tick", line_out, 1'b1);
    repeat (2) step();
    for (int h = 0; h < nh; h++) begin
      if (h > 0) repeat (HALF) step();
      chk(exp_t[h], line_out, exp_h[h]);
      if (h == nh - 1) begin
        chk("R2 ready low in last half", tx_ready, 1'b0);
        tx_valid = 1'b0;
      end
    end
    repeat (HALF) step();
    chk("R12 ready back after frame", tx_ready, 1'b1);
    chk("R12 busy clear after frame", busy, 1'b0);
    chk("R12 line idle after frame", line_out, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int idx;
    int plens [4];
    n_chk = 0; n_err = 0; done = 1'b0;
    plens = '{0, 1, 5, 15};
    rst_n = 1'b0; tx_valid = 1'b0; tx_data = '0;
    cfg_pre_pat = '0; cfg_pre_len = '0; cfg_invert = 1'b0;
    cfg_sync = 1'b0; cfg_len_sel = '0;
    repeat (3) step();
    chk("R1 line in reset", line_out, 1'b1);
    chk("R1 busy in reset", busy, 1'b0);
    chk("R1 ready in reset", tx_ready, 1'b1);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 line after reset", line_out, 1'b1);
    chk("R1 busy after reset", busy, 1'b0);
    chk("R1 ready after reset", tx_ready, 1'b1);
    idx = 0;
    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 4; l++)
        for (int v = 0; v < 2; v++)
          for (int s = 0; s < 2; s++)
            for (int c = 0; c < 4; c++) begin
              run_frame(2'(p), plens[l], v[0], s[0], 2'(c),
                        8'((idx * 53 + 17) & 8'hff), idx[0]);
              idx++;
            end
    // patterns that stress LSB order and full-length characters
    run_frame(2'd2, 3, 1'b0, 1'b0, 2'd3, 8'h01, 1'b0);
    run_frame(2'd3, 3, 1'b1, 1'b1, 2'd3, 8'h80, 1'b1);
    run_frame(2'd0, 0, 1'b0, 1'b1, 2'd0, 8'hff, 1'b0);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule